// File: doc/BRIEF.md
# Packed Dual-Halfword Saturating Shifter

This datapath unit treats a 32-bit operand as two signed 16-bit lanes and shifts both by the same count. The count runs from 0 to 15. A direction input chooses one of two shifts.

- **Left shift:** overflow clamps to the signed halfword limits instead of wrapping.
- **Right shift:** arithmetic, so vacated bits are filled with the lane's sign.

Each lane is handled alone, and no bit ever passes from one lane into the other.

Every lane also reports an overflow flag. The flag is raised exactly when that lane's left-shift result had to be clamped. The unit is one registered pipeline stage: an operand presented with `in_valid` appears at `result` together with `out_valid` one clock later. The result register only loads on valid cycles, so the last result stays on the output between operations.

Top module: `dual_lane_sat_shifter`

## Requirements
- R1: The high lane (bits 31:16, flag bit 1) and the low lane (bits 15:0, flag bit 0) are computed independently; saturation or sign of one lane never changes the other lane's result or flag.
- R2: With `dir_right`=0, a lane whose exact value x·2^n lies above 32767 yields 0x7FFF, and one below -32768 yields 0x8000.
- R3: With `dir_right`=0, `lane_ovf[i]` is 1 in the output cycle exactly when lane i was clamped, and 0 otherwise.
- R4: With `dir_right`=0 and an exact value inside the signed 16-bit range, the lane result equals the lane shifted left by n, with zeros entering from the bottom.
- R5: With `dir_right`=1, each lane result is the signed lane shifted right by n with its sign bit replicated into the vacated top bits (count 15 yields 0x0000 or 0xFFFF).
- R6: With `dir_right`=1, both overflow flags are 0.
- R7: A count of 0 returns the operand unchanged in either direction, with both flags 0.
- R8: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1 and 0 after a cycle with `in_valid`=0.
- R9: After a cycle with `in_valid`=0, `result` keeps its previous value and both flags are 0.
- R10: While `rst_n` is low, `out_valid`, `result` and `lane_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand, direction and count are valid this cycle |
| operand | input | 32 | Two packed signed halfwords |
| dir_right | input | 1 | 0 = saturating left shift, 1 = arithmetic right shift |
| shamt | input | 4 | Shift count 0..15, shared by both lanes |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 32 | Packed shifted halfwords |
| lane_ovf | output | 2 | Per-lane clamp flag (bit 1 = high lane) |

## Verification
Both directions are swept over all sixteen counts, with every pairing of the boundary halfwords 0x7FFF, 0x8000, 0x0000, 0xFFFF and 0x0001.

- The extreme values separate an off-by-one clamp threshold from a correct one.
- The -1 and +1 values expose a missing sign fill on the right and a false overflow on small negative values.

Mixed-sign directed operands show whether a lane's clamp or sign leaks into its neighbour. Seeded random operands cover the bulk of the in-range and out-of-range left shifts. Idle cycles between operations show whether the result holds and the flags drop.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  // Shift direction selected by the dir_right input.
  typedef enum logic {
    SHIFT_LEFT_SAT    = 1'b0,
    SHIFT_RIGHT_ARITH = 1'b1
  } shift_dir_e;

  localparam int unsigned DEF_LANE_W = 16;
  localparam int unsigned DEF_LANES  = 2;

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
  import shifter_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned CNT_W  = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] lane_in,
  input  shift_dir_e        dir,
  input  logic [CNT_W-1:0]  shamt,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_ovf
);

  localparam int unsigned EXT_W = 2 * LANE_W;
  localparam int unsigned TOP_W = EXT_W - LANE_W + 1;

  logic              sign_bit;
  logic [EXT_W-1:0]  ext_val;
  logic [EXT_W-1:0]  shl_val;
  logic [TOP_W-1:0]  top_bits;
  logic              left_ovf;
  logic [LANE_W-1:0] sat_val;
  logic [LANE_W-1:0] sra_val;

  assign sign_bit = lane_in[LANE_W-1];
  assign ext_val  = {{LANE_W{sign_bit}}, lane_in};
  assign shl_val  = ext_val << shamt;
  // Bits above the result sign plus the new sign bit must all equal the old sign.
  assign top_bits = shl_val[EXT_W-1:LANE_W-1];
  assign left_ovf = sign_bit ? ~(&top_bits) : (|top_bits);
  assign sat_val  = sign_bit ? {1'b1, {(LANE_W-1){1'b0}}}
                             : {1'b0, {(LANE_W-1){1'b1}}};
  assign sra_val  = LANE_W'($signed(lane_in) >>> shamt);

  always_comb begin
    lane_out = '0;
    lane_ovf = 1'b0;
    unique case (dir)
      SHIFT_LEFT_SAT: begin
        lane_ovf = left_ovf;
        lane_out = left_ovf ? sat_val : shl_val[LANE_W-1:0];
      end
      SHIFT_RIGHT_ARITH: begin
        lane_out = sra_val;
      end
      default: begin
        lane_out = '0;
      end
    endcase
  end

endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] nxt_result,
  input  logic [LANES-1:0]  nxt_ovf,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [LANES-1:0]  lane_ovf
);

  logic              valid_d;
  logic [DATA_W-1:0] result_d;
  logic [LANES-1:0]  ovf_d;

  // Next-state: result loads only on valid cycles, flags qualified by valid.
  always_comb begin
    valid_d  = load;
    result_d = load ? nxt_result : result;
    ovf_d    = load ? nxt_ovf : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      lane_ovf  <= '0;
    end else begin
      out_valid <= valid_d;
      result    <= result_d;
      lane_ovf  <= ovf_d;
    end
  end

endmodule

// File: rtl/dual_lane_sat_shifter.sv
module dual_lane_sat_shifter
  import shifter_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned CNT_W  = $clog2(LANE_W),
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic              dir_right,
  input  logic [CNT_W-1:0]  shamt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [LANES-1:0]  lane_ovf
);

  shift_dir_e        dir;
  logic [DATA_W-1:0] comb_result;
  logic [LANES-1:0]  comb_ovf;

  assign dir = dir_right ? SHIFT_RIGHT_ARITH : SHIFT_LEFT_SAT;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_shifter #(
      .LANE_W (LANE_W),
      .CNT_W  (CNT_W)
    ) u_lane (
      .lane_in  (operand[g*LANE_W +: LANE_W]),
      .dir      (dir),
      .shamt    (shamt),
      .lane_out (comb_result[g*LANE_W +: LANE_W]),
      .lane_ovf (comb_ovf[g])
    );
  end

  shift_out_stage #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (in_valid),
    .nxt_result (comb_result),
    .nxt_ovf    (comb_ovf),
    .out_valid  (out_valid),
    .result     (result),
    .lane_ovf   (lane_ovf)
  );

endmodule

// File: rtl/shifter_checker.sv
module shifter_checker #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] operand,
  input logic              dir_right,
  input logic [CNT_W-1:0]  shamt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [LANES-1:0]  lane_ovf
);

  localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && lane_ovf == '0));

  assert_right_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dir_right) |=> lane_ovf == '0);

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt == '0) |=> (result == $past(operand) && lane_ovf == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_clamp_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_ovf[g] |-> (result[g*LANE_W +: LANE_W] == POS_LIM ||
                       result[g*LANE_W +: LANE_W] == NEG_LIM));
    assert_clamp_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_ovf[g] |-> (result[g*LANE_W + LANE_W-1] ==
                       $past(operand[g*LANE_W + LANE_W-1])));
  end

endmodule

bind dual_lane_sat_shifter shifter_checker #(
  .LANE_W (LANE_W),
  .LANES  (LANES),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .dir_right (dir_right),
  .shamt     (shamt),
  .out_valid (out_valid),
  .result    (result),
  .lane_ovf  (lane_ovf)
);

// File: tb/tb_dual_lane_sat_shifter.sv
module tb_dual_lane_sat_shifter;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic        dir_right;
  logic [3:0]  shamt;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  lane_ovf;

  int checks;
  int failures;
  bit finished;

  dual_lane_sat_shifter dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .dir_right (dir_right),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result),
    .lane_ovf  (lane_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference lane: {clamped, value} from wide signed arithmetic.
  function automatic logic [16:0] ref_lane(logic [15:0] x, logic right, int n);
    int v;
    v = int'($signed(x));
    if (right) begin
      v = v >>> n;
      return {1'b0, v[15:0]};
    end
    v = v * (1 << n);
    if (v > 32767)  return {1'b1, 16'h7FFF};
    if (v < -32768) return {1'b1, 16'h8000};
    return {1'b0, v[15:0]};
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation and check the registered outputs one clock later.
  task automatic run_vec(logic [31:0] op, logic right, int n);
    logic [16:0] hi;
    logic [16:0] lo;
    string tag;
    @(negedge clk);
    operand   = op;
    dir_right = right;
    shamt     = 4'(n);
    in_valid  = 1'b1;
    hi = ref_lane(op[31:16], right, n);
    lo = ref_lane(op[15:0],  right, n);
    @(negedge clk);
    in_valid = 1'b0;
    if (n == 0)              tag = "R7 zero count";
    else if (right)          tag = "R5 arithmetic right";
    else if (hi[16] | lo[16]) tag = "R2 clamp";
    else                     tag = "R4 in-range left";
    check32(tag, result, {hi[15:0], lo[15:0]});
    check32(right ? "R6 right flags" : "R3 left flags",
            {30'd0, lane_ovf}, {30'd0, hi[16], lo[16]});
    check32("R8 out_valid", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic run_exact(string tag, logic [31:0] op, logic right, int n,
                           logic [31:0] exp_res, logic [1:0] exp_ovf);
    @(negedge clk);
    operand = op; dir_right = right; shamt = 4'(n); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check32(tag, result, exp_res);
    check32(tag, {30'd0, lane_ovf}, {30'd0, exp_ovf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] bnd [5];
    logic [31:0] last;
    int unsigned seed;
    checks = 0; failures = 0; finished = 0;
    bnd[0] = 16'h7FFF; bnd[1] = 16'h8000; bnd[2] = 16'h0000;
    bnd[3] = 16'hFFFF; bnd[4] = 16'h0001;
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; dir_right = 1'b0; shamt = '0;
    repeat (3) @(negedge clk);
    check32("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check32("R10 reset result", result, 32'd0);
    check32("R10 reset flags", {30'd0, lane_ovf}, 32'd0);
    rst_n = 1'b1;

    // Directed vectors
    run_exact("R7 unchanged", 32'h01230ABC, 1'b0, 0, 32'h01230ABC, 2'b00);
    run_exact("R2 both clamp", 32'h12345678, 1'b0, 3, 32'h7FFF7FFF, 2'b11);
    run_exact("R2 mixed clamp", 32'h456789AB, 1'b0, 9, 32'h7FFF8000, 2'b11);
    run_exact("R5 right 4", 32'h56789ABC, 1'b1, 4, 32'h0567F9AB, 2'b00);
    run_exact("R5 right 9", 32'h6789ABCD, 1'b1, 9, 32'h0033FFD5, 2'b00);
    run_exact("R5 right 14", 32'h23456789, 1'b1, 14, 32'h00000001, 2'b00);
    run_exact("R5 right 15", 32'h00018000, 1'b1, 15, 32'h0000FFFF, 2'b00);
    run_exact("R1 high clamps only", 32'h7FFF0001, 1'b0, 1, 32'h7FFF0002, 2'b10);
    run_exact("R1 low clamps only", 32'hFFFF8000, 1'b0, 1, 32'hFFFE8000, 2'b01);
    run_exact("R4 small negative", 32'hFFFFC000, 1'b0, 1, 32'hFFFE8000, 2'b00);

    // Idle cycle: result holds, flags drop (R9, R8)
    last = result;
    @(negedge clk);
    check32("R9 hold result", result, last);
    check32("R9 flags idle", {30'd0, lane_ovf}, 32'd0);
    check32("R8 idle valid", {31'd0, out_valid}, 32'd0);

    // Boundary sweep
    for (int d = 0; d < 2; d++)
      for (int n = 0; n < 16; n++)
        for (int h = 0; h < 5; h++)
          for (int l = 0; l < 5; l++)
            run_vec({bnd[h], bnd[l]}, d[0], n);

    // Seeded random
    seed = $urandom(32'd2024);
    for (int k = 0; k < 3000; k++)
      run_vec($urandom, 1'($urandom), int'($urandom % 16));

    // Reset in mid-run (R10)
    run_exact("R2 before reset", 32'h40004000, 1'b0, 2, 32'h7FFF7FFF, 2'b11);
    @(negedge clk);
    operand = 32'h7FFF7FFF; shamt = 4'd5; dir_right = 1'b0; in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check32("R10 mid reset result", result, 32'd0);
    check32("R10 mid reset valid", {31'd0, out_valid}, 32'd0);
    check32("R10 mid reset flags", {30'd0, lane_ovf}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    run_vec(32'h8000FFFF, 1'b0, 15);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule